// File: doc/BRIEF.md
# Ramped I/Q Setpoint Sequencer

This block supplies the in-phase and quadrature setpoint that the cavity vector-sum feedback loop regulates to, over each booster energy-ramp cycle. A host fills a table of 50 points through a simple register write port. Each point holds one I word and one Q word, and one more register holds the step interval in clock ticks. The curve (a flat injection level, a linear rise, then a flat top) is computed on the host side and reaches the block only as table contents.

Writes always land in a shadow copy of the table. A rising edge on the timing trigger copies the shadow table into the active table, resets the point index to zero and raises the run flag. The index then advances once every interval. When the last point is reached the run flag drops, and the final I/Q pair stays on the output until the next trigger. A trigger that arrives in the middle of a ramp restarts it from point zero. A table rewrite made during a ramp therefore never disturbs the curve in progress.

Top module: `ramp_iq_seq`

## Requirements
- R1: After reset the run flag is low, both setpoint outputs are zero and the step interval is the parameter default (125000 ticks, 5 ms per point at 25 MHz).
- R2: A write to address 2k (k = 0..49) sets the I word of point k and a write to address 2k+1 sets its Q word, both from the low 16 data bits. A write to address 100 sets the step interval from the low 20 data bits. Writes reach only the shadow table, so the outputs do not change until a trigger.
- R3: On the clock edge that first samples the trigger high, the shadow table is copied to the active table, the index goes to 0 and the run flag rises. Point 0 is on the outputs after that edge.
- R4: While running, each point is presented for exactly the programmed interval in clock cycles. An interval of 0 behaves like 1.
- R5: On the edge where the index reaches the last point (49), the run flag falls. The outputs then hold the final I/Q pair and the index does not move until the next trigger.
- R6: A trigger during a ramp restarts the sequence at point 0 with the run flag high.
- R7: A write made during a ramp does not change the pair or the timing of the ramp in progress. It takes effect from the next trigger.
- R8: Only a rising edge of the trigger starts a cycle. A trigger held high for several cycles does not restart the ramp on every cycle.
- R9: Writes to addresses 101 and above change neither a point nor the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 20 | Register write data |
| trig_i | input | 1 | Ramp start trigger, acting on its rising edge |
| run_o | output | 1 | High while the ramp is stepping |
| sp_i_o | output | 16 | In-phase setpoint |
| sp_q_o | output | 16 | Quadrature setpoint |

## Verification
The bench walks a full 50-point ramp and samples on both sides of each step boundary, including the edge where the last point is reached. An off-by-one in the interval counter would show up as a step one cycle early or late, and a run flag that falls one point too early or too late is caught at the same time. It rewrites a point during a ramp and checks that the old value is still seen, and that the new value appears only after the next trigger, which exposes a design that writes straight into the live table. It also retriggers mid-ramp, holds the trigger high to expose level-sensitive restarts, writes to unmapped addresses to catch aliasing onto the interval register, and programs a zero interval to catch a counter that stalls or wraps.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

  typedef enum logic [1:0] {
    AK_I    = 2'd0,
    AK_Q    = 2'd1,
    AK_IVAL = 2'd2,
    AK_NONE = 2'd3
  } addr_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } run_state_e;

  // Address layout: even/odd pairs per point, then the interval word.
  function automatic addr_kind_e f_decode(input int unsigned addr, input int unsigned n_pts);
    if (addr < 2 * n_pts) begin
      return (addr[0]) ? AK_Q : AK_I;
    end else if (addr == 2 * n_pts) begin
      return AK_IVAL;
    end
    return AK_NONE;
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/seq_regbank.sv
module seq_regbank
  import ramp_seq_pkg::*;
#(
  parameter int N_PTS    = 50,
  parameter int DATA_W   = 16,
  parameter int TICK_W   = 20,
  parameter int WR_W     = 20,
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 6,
  parameter int DEF_IVAL = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_i_o,
  output logic [DATA_W-1:0] rd_q_o,
  output logic [TICK_W-1:0] ival_o
);

  addr_kind_e  kind;
  int unsigned wr_pt;

  always_comb begin
    kind  = f_decode(int'(wr_addr), N_PTS);
    wr_pt = int'(wr_addr) >> 1;
  end

  logic [DATA_W-1:0] act_i_arr [N_PTS];
  logic [DATA_W-1:0] act_q_arr [N_PTS];

  for (genvar p = 0; p < N_PTS; p++) begin : g_pt
    logic              we_i, we_q;
    logic [DATA_W-1:0] sh_i_q, sh_q_q, ac_i_q, ac_q_q;

    assign we_i = wr_en && (kind == AK_I) && (wr_pt == p);
    assign we_q = wr_en && (kind == AK_Q) && (wr_pt == p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_i_q <= '0;
        sh_q_q <= '0;
      end else begin
        if (we_i) sh_i_q <= wr_data[DATA_W-1:0];
        if (we_q) sh_q_q <= wr_data[DATA_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ac_i_q <= '0;
        ac_q_q <= '0;
      end else if (load_i) begin
        ac_i_q <= sh_i_q;
        ac_q_q <= sh_q_q;
      end
    end

    assign act_i_arr[p] = ac_i_q;
    assign act_q_arr[p] = ac_q_q;
  end

  logic              we_iv;
  logic [TICK_W-1:0] sh_iv_q, ac_iv_q;

  assign we_iv = wr_en && (kind == AK_IVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_iv_q <= TICK_W'(DEF_IVAL);
      ac_iv_q <= TICK_W'(DEF_IVAL);
    end else begin
      if (we_iv)  sh_iv_q <= wr_data[TICK_W-1:0];
      if (load_i) ac_iv_q <= sh_iv_q;
    end
  end

  assign rd_i_o = act_i_arr[rd_idx];
  assign rd_q_o = act_q_arr[rd_idx];
  assign ival_o = ac_iv_q;

  AST_IVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ival_o)); // R7

endmodule

// File: rtl/seq_pacer.sv
module seq_pacer #(
  parameter int TICK_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [TICK_W-1:0] ival_i,
  output logic              adv_o
);

  logic [TICK_W-1:0] cnt_q, cnt_d, ival_m1;

  always_comb begin
    ival_m1 = (ival_i == '0) ? '0 : ival_i - TICK_W'(1);
    cnt_d   = cnt_q;
    adv_o   = 1'b0;
    if (start_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      if (cnt_q >= ival_m1) begin
        adv_o = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_ADV_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> run_i); // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !start_i |-> cnt_q <= ival_m1 || $past(start_i)); // R4

endmodule

// File: rtl/seq_indexer.sv
module seq_indexer
  import ramp_seq_pkg::*;
#(
  parameter int N_PTS = 50,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             run_o
);

  localparam int LAST = N_PTS - 1;

  run_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (start_i) begin
      idx_d = '0;
      st_d  = (N_PTS > 1) ? ST_RAMP : ST_IDLE;
    end else if (st_q == ST_RAMP && adv_i) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(LAST - 1)) begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;
  assign run_o = (st_q == ST_RAMP);

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> idx_o == '0 && run_o); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && adv_i && !start_i |=> idx_o == $past(idx_o) + IDX_W'(1)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o && !start_i |=> $stable(idx_o)); // R5

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= IDX_W'(LAST)); // R5

endmodule

// File: rtl/ramp_iq_seq.sv
module ramp_iq_seq #(
  parameter  int N_PTS    = 50,
  parameter  int DATA_W   = 16,
  parameter  int TICK_W   = 20,
  parameter  int DEF_IVAL = 125000,
  localparam int ADDR_W   = $clog2(2 * N_PTS + 1),
  localparam int WR_W     = (DATA_W > TICK_W) ? DATA_W : TICK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              trig_i,
  output logic              run_o,
  output logic [DATA_W-1:0] sp_i_o,
  output logic [DATA_W-1:0] sp_q_o
);

  localparam int IDX_W = (N_PTS > 1) ? $clog2(N_PTS) : 1;

  logic              srst_n;
  logic              trig_q;
  logic              start;
  logic              adv;
  logic [IDX_W-1:0]  idx;
  logic [TICK_W-1:0] ival;

  seq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
    end
  end

  assign start = trig_i && !trig_q;

  seq_regbank #(
    .N_PTS    (N_PTS),
    .DATA_W   (DATA_W),
    .TICK_W   (TICK_W),
    .WR_W     (WR_W),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .DEF_IVAL (DEF_IVAL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load_i  (start),
    .rd_idx  (idx),
    .rd_i_o  (sp_i_o),
    .rd_q_o  (sp_q_o),
    .ival_o  (ival)
  );

  seq_pacer #(
    .TICK_W (TICK_W)
  ) u_pace (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start),
    .run_i   (run_o),
    .ival_i  (ival),
    .adv_o   (adv)
  );

  seq_indexer #(
    .N_PTS (N_PTS),
    .IDX_W (IDX_W)
  ) u_idx (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start),
    .adv_i   (adv),
    .idx_o   (idx),
    .run_o   (run_o)
  );

  AST_LEVEL_NO_RESTART: assert property (@(posedge clk) disable iff (!srst_n)
    trig_i && trig_q && run_o && !adv |=> $stable(sp_i_o) && $stable(sp_q_o)); // R8

endmodule

// File: tb/ramp_iq_seq_bench.sv
module ramp_iq_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N  = 50;
  localparam int DW = 16;
  localparam int AW = 7;
  localparam int WW = 20;

  typedef struct packed {
    int off;
    int idx;
    bit run;
  } vec_t;

  // Ramp walk with interval 4: idx = off/4 capped at 49, run low from off 196.
  localparam vec_t VEC [12] = '{
    '{0, 0, 1'b1},   '{3, 0, 1'b1},   '{4, 1, 1'b1},    '{7, 1, 1'b1},
    '{8, 2, 1'b1},   '{41, 10, 1'b1}, '{100, 25, 1'b1}, '{195, 48, 1'b1},
    '{196, 49, 1'b0}, '{197, 49, 1'b0}, '{230, 49, 1'b0}, '{400, 49, 1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_data;
  logic          trig_i;
  logic          run_o;
  logic [DW-1:0] sp_i_o;
  logic [DW-1:0] sp_q_o;

  ramp_iq_seq u_ramp_iq_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .trig_i  (trig_i),
    .run_o   (run_o),
    .sp_i_o  (sp_i_o),
    .sp_q_o  (sp_q_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int off    = 0;

  logic [DW-1:0] sh_i [N];
  logic [DW-1:0] sh_q [N];
  logic [DW-1:0] ac_i [N];
  logic [DW-1:0] ac_q [N];

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    summary();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    off += n;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = WW'(data);
    if (addr < 2 * N) begin
      if (addr % 2 == 0) sh_i[addr / 2] = DW'(data);
      else               sh_q[addr / 2] = DW'(data);
    end
    @(negedge clk);
    wr_en = 1'b0;
    off += 2;
  endtask

  task automatic load_model();
    for (int k = 0; k < N; k++) begin
      ac_i[k] = sh_i[k];
      ac_q[k] = sh_q[k];
    end
  endtask

  task automatic trig_pulse();
    @(negedge clk);
    trig_i = 1'b1;
    load_model();
    @(negedge clk);
    trig_i = 1'b0;
    off = 0;
  endtask

  task automatic chk(input string tag, input int idx, input bit run);
    n_chk++;
    if (sp_i_o !== ac_i[idx] || sp_q_o !== ac_q[idx] || run_o !== run) begin
      n_fail++;
      $display("FAIL %s off=%0d: actual i=%h q=%h run=%b expected i=%h q=%h run=%b",
               tag, off, sp_i_o, sp_q_o, run_o, ac_i[idx], ac_q[idx], run);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    trig_i  = 1'b0;
    for (int k = 0; k < N; k++) begin
      sh_i[k] = '0; sh_q[k] = '0; ac_i[k] = '0; ac_q[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 0, 1'b0);

    for (int k = 0; k < N; k++) begin
      wr(2 * k, 1000 + 37 * k);
      wr(2 * k + 1, -(500 + 11 * k));
    end
    wr(100, 4);
    chk("R2 writes stay in shadow", 0, 1'b0);

    trig_pulse();
    for (int v = 0; v < 12; v++) begin
      step(VEC[v].off - off);
      chk((VEC[v].run) ? "R4 ramp step timing" : "R5 final hold", VEC[v].idx, VEC[v].run);
    end

    // R7 mid-ramp rewrite and R9 unmapped writes
    trig_pulse();
    chk("R3 trigger loads point 0", 0, 1'b1);
    step(9);
    wr(10, 16'h7777);
    chk("R7 current pair unchanged", 2, 1'b1);
    step(20 - off);
    chk("R7 old value kept in running ramp", 5, 1'b1);
    wr(101, 7);
    wr(127, 9);
    step(30 - off);
    chk("R7 timing unchanged", 7, 1'b1);

    trig_pulse();
    chk("R6 retrigger restarts at 0", 0, 1'b1);
    step(20);
    chk("R7 new value after trigger", 5, 1'b1);
    step(3);
    chk("R9 interval unaffected", 5, 1'b1);
    step(1);
    chk("R9 interval unaffected step", 6, 1'b1);

    // R8 held trigger
    @(negedge clk);
    trig_i = 1'b1;
    load_model();
    @(negedge clk);
    off = 0;
    step(7);
    chk("R8 held trigger no restart", 1, 1'b1);
    trig_i = 1'b0;
    step(1);
    chk("R8 after release", 2, 1'b1);

    // R4 zero interval acts as one
    wr(100, 0);
    trig_pulse();
    chk("R4 zero interval start", 0, 1'b1);
    step(3);
    chk("R4 zero interval per-cycle step", 3, 1'b1);
    step(45);
    chk("R4 zero interval before end", 48, 1'b1);
    step(1);
    chk("R5 run falls at last point", 49, 1'b0);
    step(30);
    chk("R5 final pair held", 49, 1'b0);

    summary();
  end

endmodule